// File: doc/BRIEF.md
# Fly-by DMA Peripheral Strobe Generator

This block sits beside one or more peripherals that take part in single-cycle (fly-by) DMA transfers. During such a transfer the DMA controller runs an ordinary memory bus cycle and the data never passes through it: the peripheral and the memory exchange data directly on the shared bus. The block makes that work. It watches one active-low acknowledge line per channel together with the memory read and write strobes of the cycle under way. It then drives the opposite strobe on the peripheral. A memory write gets a peripheral read, so the peripheral drives the bus and memory latches. A memory read gets a peripheral write, so memory drives the bus and the peripheral latches.

A peripheral is selected by its acknowledge line alone, and no address enters the block. Every processor bus control signal stays on the memory side, so these strobes are the only ones the peripherals see. Each strobe starts on the clock edge that first samples a valid request. It stays asserted through wait states and drops on the edge that samples ready asserted. It does not return until the bus cycle has ended. A data-drive enable lets the peripheral's output buffers onto the bus only during a peripheral read.

Top module: `fb_dma_strobe`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), and after it, every per_rd_n and per_wr_n is 1 and every per_oe is 0 until a transfer starts.
- R2: When a clock edge samples cyc_act=1, exactly one chan_ack_n bit low, mem_wr_n=0 and mem_rd_n=1, that channel's per_rd_n goes to 0 after that edge.
- R3: When a clock edge samples cyc_act=1, exactly one chan_ack_n bit low, mem_rd_n=0 and mem_wr_n=1, that channel's per_wr_n goes to 0 after that edge.
- R4: per_oe of a channel is 1 only while that channel's per_rd_n is 0 and its acknowledge is low. It is never 1 during a peripheral write.
- R5: An active strobe is released on the clock edge that samples rdy_n=0. It does not assert again until cyc_act has been sampled 0 or the acknowledge has been released.
- R6: A strobe never is 0 while its channel's chan_ack_n is 1. Raising the acknowledge removes the strobe without waiting for a clock edge.
- R7: If mem_rd_n and mem_wr_n are both 1, or both 0, no strobe starts.
- R8: If more than one chan_ack_n bit is low at the sampling edge, no strobe starts on any channel.
- R9: If cyc_act is 0 at the sampling edge, no strobe starts. The strobes of channels whose acknowledge is high stay at 1 while another channel transfers.
- R10: While rdy_n stays 1, an active strobe stays asserted through any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_ack_n | input | N_CH | Per-channel DMA acknowledge, active low |
| mem_rd_n | input | 1 | Memory read strobe of current cycle, active low |
| mem_wr_n | input | 1 | Memory write strobe of current cycle, active low |
| cyc_act | input | 1 | High while a bus cycle is in progress |
| rdy_n | input | 1 | Bus ready, active low, ends the cycle |
| per_rd_n | output | N_CH | Peripheral read strobe per channel, active low |
| per_wr_n | output | N_CH | Peripheral write strobe per channel, active low |
| per_oe | output | N_CH | Peripheral data-drive enable per channel |

## Verification
The hardest state to reach from the ports is the hold-off after ready. There the strobe has been released, but the acknowledge, the memory strobe and the cycle qualifier are all still asserted, so a naive design would fire again. The bench reaches it by keeping every request input steady for a cycle after ready and checking that the strobe stays high. It then drops cyc_act to show that the next cycle is accepted. A second hard case is acknowledge rising in mid-strobe. The bench checks this between clock edges to show that the release does not wait for a register.

// File: rtl/fb_pkg.sv
// Package: shared state encoding for the fly-by strobe generator.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package fb_pkg;

    // Per-channel strobe sequencer state.
    typedef enum logic [1:0] {
        FB_IDLE = 2'd0,  // no strobe, waiting for a request
        FB_RD   = 2'd1,  // peripheral read strobe (memory write cycle)
        FB_WR   = 2'd2,  // peripheral write strobe (memory read cycle)
        FB_HOLD = 2'd3   // ready seen, waiting for the bus cycle to end
    } fb_state_e;

endpackage

// File: rtl/fb_start_qual.sv
// Module: fb_start_qual
// Decides, each cycle, which channel (if any) may begin a strobe and in
// which direction. A start needs an active bus cycle, exactly one
// acknowledge low and exactly one memory strobe low.
// Assumes: all inputs are synchronous to the bus clock.
module fb_start_qual #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ack_n,
    input  logic            mem_rd_n,
    input  logic            mem_wr_n,
    input  logic            cyc_act,
    output logic [N_CH-1:0] start_rd,
    output logic [N_CH-1:0] start_wr
);
    localparam int CW = $clog2(N_CH + 1);

    logic [N_CH-1:0] ack_lo;
    logic [CW-1:0]   ack_cnt;
    logic            one_ack;
    logic            dir_rd;   // memory write cycle -> peripheral read
    logic            dir_wr;   // memory read cycle  -> peripheral write

    assign ack_lo = ~ack_n;

    // Count how many acknowledges are asserted this cycle.
    always_comb begin
        ack_cnt = '0;
        for (int i = 0; i < N_CH; i++) begin
            ack_cnt = ack_cnt + CW'(ack_lo[i]);
        end
    end

    // Qualify the transfer: single acknowledge and a clear direction.
    always_comb begin
        one_ack = (ack_cnt == CW'(1));
        dir_rd  = cyc_act && one_ack && !mem_wr_n &&  mem_rd_n;
        dir_wr  = cyc_act && one_ack &&  mem_wr_n && !mem_rd_n;
    end

    // Route the direction to the acknowledged channel only.
    always_comb begin
        start_rd = dir_rd ? ack_lo : '0;
        start_wr = dir_wr ? ack_lo : '0;
    end

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_rd | start_wr)) else $error("AST_ONE_START"); // R8
    AST_NO_START_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_act |-> ((start_rd | start_wr) == '0)) else $error("AST_NO_START_IDLE_BUS"); // R9
    AST_NO_START_AMBIG: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_n == mem_wr_n) |-> ((start_rd | start_wr) == '0)) else $error("AST_NO_START_AMBIG"); // R7

endmodule

// File: rtl/fb_chan_seq.sv
// Module: fb_chan_seq
// One channel's strobe sequencer. A start request moves it into a strobe
// state. Ready sampled low ends the strobe and parks it in a hold state
// until the bus cycle ends. The strobes are gated by the live acknowledge,
// so they drop at once if the acknowledge is withdrawn.
// Assumes: start_rd and start_wr are never both high.
module fb_chan_seq
    import fb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    input  logic cyc_act,
    input  logic rdy_n,
    input  logic start_rd,
    input  logic start_wr,
    output logic per_rd_n,
    output logic per_wr_n,
    output logic per_oe
);
    fb_state_e state, state_nx;

    // Next-state selection for the strobe sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            FB_IDLE: begin
                if (start_rd)      state_nx = FB_RD;
                else if (start_wr) state_nx = FB_WR;
            end
            FB_RD, FB_WR: begin
                if (ack_n || !cyc_act) state_nx = FB_IDLE;
                else if (!rdy_n)       state_nx = FB_HOLD;
            end
            FB_HOLD: begin
                if (ack_n || !cyc_act) state_nx = FB_IDLE;
            end
            default: state_nx = FB_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FB_IDLE;
        else        state <= state_nx;
    end

    // Output decode, gated by the live acknowledge.
    always_comb begin
        per_rd_n = !((state == FB_RD) && !ack_n);
        per_wr_n = !((state == FB_WR) && !ack_n);
        per_oe   =  (state == FB_RD) && !ack_n;
    end

    AST_OE_ONLY_PERIPH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        per_oe |-> (!per_rd_n && per_wr_n && !ack_n)) else $error("AST_OE_ONLY_PERIPH_READ"); // R4
    AST_NO_STROBE_WO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> (per_rd_n && per_wr_n)) else $error("AST_NO_STROBE_WO_ACK"); // R6
    AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((!per_rd_n || !per_wr_n) && !rdy_n) |=> (per_rd_n && per_wr_n)) else $error("AST_RELEASE_ON_READY"); // R5
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd_n && per_wr_n && !ack_n && cyc_act && !$past(rdy_n) && !$past(per_rd_n && per_wr_n))
        |=> (per_rd_n && per_wr_n)) else $error("AST_NO_REFIRE"); // R5
    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_rd_n && rdy_n && cyc_act && !ack_n) |=> (!per_rd_n || ack_n)) else $error("AST_HOLD_IN_WAIT"); // R10
    AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd_n || per_wr_n)) else $error("AST_EXCL"); // R4

endmodule

// File: rtl/fb_dma_strobe.sv
// Module: fb_dma_strobe (top)
// Generates peripheral read/write strobes for fly-by DMA. A memory write
// cycle gives a peripheral read, a memory read cycle gives a peripheral
// write. The peripheral is selected by its acknowledge line only.
// Assumes: memory strobes and acknowledges are synchronous to clk; at most
// one acknowledge is meant to be active at a time.
module fb_dma_strobe #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_ack_n,
    input  logic            mem_rd_n,
    input  logic            mem_wr_n,
    input  logic            cyc_act,
    input  logic            rdy_n,
    output logic [N_CH-1:0] per_rd_n,
    output logic [N_CH-1:0] per_wr_n,
    output logic [N_CH-1:0] per_oe
);
    logic [N_CH-1:0] start_rd;
    logic [N_CH-1:0] start_wr;

    fb_start_qual #(.N_CH(N_CH)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (chan_ack_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .cyc_act  (cyc_act),
        .start_rd (start_rd),
        .start_wr (start_wr)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        fb_chan_seq u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .ack_n    (chan_ack_n[g]),
            .cyc_act  (cyc_act),
            .rdy_n    (rdy_n),
            .start_rd (start_rd[g]),
            .start_wr (start_wr[g]),
            .per_rd_n (per_rd_n[g]),
            .per_wr_n (per_wr_n[g]),
            .per_oe   (per_oe[g])
        );
    end

    AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~per_rd_n | ~per_wr_n)) else $error("AST_SINGLE_ACTIVE"); // R9
    AST_RD_FOLLOWS_MEMWR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_rd_n != '1) |-> $past(!mem_wr_n && mem_rd_n)) else $error("AST_RD_FOLLOWS_MEMWR"); // R2
    AST_WR_FOLLOWS_MEMRD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_wr_n != '1) |-> $past(!mem_rd_n && mem_wr_n)) else $error("AST_WR_FOLLOWS_MEMRD"); // R3

endmodule

// File: tb/tb_fb_dma_strobe.sv
module tb_fb_dma_strobe;
    localparam int N_CH    = 4;
    localparam int CLK_PER = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N_CH-1:0] chan_ack_n;
    logic            mem_rd_n, mem_wr_n, cyc_act, rdy_n;
    logic [N_CH-1:0] per_rd_n, per_wr_n, per_oe;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    fb_dma_strobe #(.N_CH(N_CH)) dut (
        .clk(clk), .rst_n(rst_n), .chan_ack_n(chan_ack_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .cyc_act(cyc_act),
        .rdy_n(rdy_n), .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .per_oe(per_oe)
    );

    task automatic chk(input string req, input logic [3*N_CH-1:0] act,
                       input logic [3*N_CH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {rd_n,wr_n,oe} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3*N_CH-1:0] outs();
        return {per_rd_n, per_wr_n, per_oe};
    endfunction

    localparam logic [3*N_CH-1:0] QUIET = {{N_CH{1'b1}}, {N_CH{1'b1}}, {N_CH{1'b0}}};

    function automatic logic [3*N_CH-1:0] exp_rd(input int ch);
        logic [N_CH-1:0] m = N_CH'(1) << ch;
        return {~m, {N_CH{1'b1}}, m};
    endfunction

    function automatic logic [3*N_CH-1:0] exp_wr(input int ch);
        logic [N_CH-1:0] m = N_CH'(1) << ch;
        return {{N_CH{1'b1}}, ~m, {N_CH{1'b0}}};
    endfunction

    task automatic idle_bus();
        @(negedge clk);
        chan_ack_n = '1; mem_rd_n = 1; mem_wr_n = 1; cyc_act = 0; rdy_n = 1;
        @(posedge clk); #1;
    endtask

    // Full transfer: start, wait states, ready, hold-off, end.
    task automatic t_xfer(input int ch, input bit periph_rd, input int waits);
        logic [3*N_CH-1:0] e = periph_rd ? exp_rd(ch) : exp_wr(ch);
        string rq = periph_rd ? "R2" : "R3";
        @(negedge clk);
        chan_ack_n = '1; chan_ack_n[ch] = 0; cyc_act = 1; rdy_n = 1;
        mem_wr_n = periph_rd ? 1'b0 : 1'b1;
        mem_rd_n = periph_rd ? 1'b1 : 1'b0;
        @(posedge clk); #1;
        chk(rq, outs(), e);
        for (int w = 0; w < waits; w++) begin
            @(posedge clk); #1;
            chk("R10", outs(), e);
        end
        @(negedge clk); rdy_n = 0;
        @(posedge clk); #1;
        chk("R5 release", outs(), QUIET);
        @(negedge clk); rdy_n = 1;
        @(posedge clk); #1;
        chk("R5 no refire", outs(), QUIET);
        idle_bus();
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 0; chan_ack_n = '1; chan_ack_n[0] = 0; cyc_act = 1;
        mem_wr_n = 0; mem_rd_n = 1; rdy_n = 1;
        @(posedge clk); #1;
        chk("R1", outs(), QUIET);
        @(negedge clk); rst_n = 1; chan_ack_n = '1; cyc_act = 0; mem_wr_n = 1;
        @(posedge clk); #1;
        chk("R1 after", outs(), QUIET);
    endtask

    task automatic t_no_start(input string rq, input logic [N_CH-1:0] a,
                              input logic r, input logic w, input logic c);
        @(negedge clk);
        chan_ack_n = a; mem_rd_n = r; mem_wr_n = w; cyc_act = c; rdy_n = 1;
        @(posedge clk); #1;
        chk(rq, outs(), QUIET);
        @(posedge clk); #1;
        chk(rq, outs(), QUIET);
        idle_bus();
    endtask

    task automatic t_ack_drop();
        @(negedge clk);
        chan_ack_n = '1; chan_ack_n[2] = 0; cyc_act = 1; mem_wr_n = 0; mem_rd_n = 1; rdy_n = 1;
        @(posedge clk); #1;
        chk("R2 ch2", outs(), exp_rd(2));
        #2; chan_ack_n[2] = 1; #1;
        chk("R6 immediate", outs(), QUIET);
        @(posedge clk); #1;
        chk("R6 stays off", outs(), QUIET);
        idle_bus();
    endtask

    // R5: after the hold-off, dropping cyc_act lets the next cycle start.
    task automatic t_back_to_back();
        t_xfer(3, 1'b0, 0);
        t_xfer(3, 1'b1, 1);
    endtask

    initial begin
        fork
            begin
                rst_n = 0; chan_ack_n = '1; mem_rd_n = 1; mem_wr_n = 1; cyc_act = 0; rdy_n = 1;
                repeat (2) @(posedge clk);
                t_reset();
                t_xfer(0, 1'b1, 0);
                t_xfer(1, 1'b0, 2);
                t_xfer(2, 1'b1, 3);
                t_no_start("R7 neither", 4'b1110, 1'b1, 1'b1, 1'b1);
                t_no_start("R7 both", 4'b1110, 1'b0, 1'b0, 1'b1);
                t_no_start("R8 two acks", 4'b1010, 1'b1, 1'b0, 1'b1);
                t_no_start("R9 no cycle", 4'b1011, 1'b1, 1'b0, 1'b0);
                t_no_start("R6 no ack", 4'b1111, 1'b0, 1'b1, 1'b1);
                t_ack_drop();
                t_back_to_back();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule